// File: doc/BRIEF.md
# Function-Coded Host Parallel Port

This block is the host-facing port of a signal processor core. A host selects the port with an active-low chip select and presents a 4-bit function code and a read/write direction bit. The block samples the code once per instruction cycle, at a strobe from the core's sequencer. It then moves data between the host's 16-bit data bus and the core's input and output registers, either a byte at a time on the low data lines or as a full 16-bit word.

Two write-only codes load the control register or the program counter from the low data byte. While either of these codes stays sampled, the core is frozen by a stop request. The request drops at the first instruction-cycle strobe that sees a different code. When the sampled code leaves a data-transfer code, the block emits a one-cycle end-of-transfer interrupt request.

The three-state bus is split into an input, an output and an output enable, and the pad sits at chip level. The core's output register arrives as an input. The input register, control register and program counter leave as outputs.

Top module: `fcode_host_port`

## Requirements
- R1: After reset the input register, control register and program counter are zero, stop_o and xfer_irq_o are low, and data_oe_o is low.
- R2: While cs_ni is high the function code is ignored: no register loads, no stop request, and the bus is not driven, whatever func_i and rd_wr_i are.
- R3: Code 4'b0010 is a low-byte transfer. A write (rd_wr_i=0) loads data_i[7:0] into input register bits 7..0 and leaves bits 15..8 unchanged. A read (rd_wr_i=1) asserts data_oe_o and drives output register bits 7..0 on data_o[7:0], with data_o[15:8]=0. The bus is never driven during a write.
- R4: Code 4'b0011 with control bit 0 (byte/word mode) at 0 is an upper-byte transfer over data lines 7..0. A write loads data_i[7:0] into input register bits 15..8. A read drives output register bits 15..8 on data_o[7:0], with data_o[15:8]=0.
- R5: Code 4'b0011 with control bit 0 at 1 is a 16-bit word transfer. A write loads all of data_i, and a read drives all of the output register on data_o.
- R6: Code 4'b0100 with a write loads data_i[7:0] into the control register.
- R7: Code 4'b1000 with a write loads data_i[7:0] into the program counter and sets control bit 7 (interrupt mask) in the same update.
- R8: stop_o rises in the cycle after an instruction-cycle strobe samples code 4'b0100 or 4'b1000. It stays high until a later strobe samples a different code, then falls in the next cycle.
- R9: Codes are sampled only when cyc_end_i is high. A write is performed only when the sampled code differs from the previously sampled one, so a code held over several strobes makes one transfer only.
- R10: xfer_irq_o pulses high for exactly one cycle after a strobe at which the sampled code changes away from 4'b0010 or 4'b0011.
- R11: Code 4'b0000 and all codes other than 0010, 0011, 0100 and 1000 do nothing: no loads, no stop request, and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_end_i | input | 1 | Instruction-cycle strobe, samples the function code |
| cs_ni | input | 1 | Active-low chip select |
| func_i | input | 4 | Function code |
| rd_wr_i | input | 1 | 1 = host read, 0 = host write |
| data_i | input | 16 | Bus value driven by the host |
| data_o | output | 16 | Bus value driven by the port |
| data_oe_o | output | 1 | Bus output enable |
| out_reg_i | input | 16 | Core output register |
| in_reg_o | output | 16 | Input register loaded by the host |
| ctrl_o | output | 8 | Control register (bit 0 word mode, bit 7 interrupt mask) |
| pc_o | output | 8 | Program counter load value |
| stop_o | output | 1 | Core stop request |
| xfer_irq_o | output | 1 | End-of-parallel-transfer interrupt pulse |

## Verification
The bench holds a transfer code over several strobes while changing the data lines. A design that edge-detected incorrectly would overwrite the input register on every strobe. It changes the code while the strobe is low and checks that stop_o stays high, which catches a design that releases on the raw code rather than on the sampled one. It runs code 0011 both before and after setting the word-mode bit, so a wrong lane or a mode read from the wrong bit shows up as a misplaced byte. It also checks that a program-counter load leaves the interrupt mask set and that a deselected port ignores load codes, where a faulty design would corrupt the control register.

// File: rtl/fchp_pkg.sv
package fchp_pkg;
  localparam int FC_W = 4;
  localparam logic [FC_W-1:0] FC_NOP  = 4'b0000;
  localparam logic [FC_W-1:0] FC_LOW  = 4'b0010;
  localparam logic [FC_W-1:0] FC_HIGH = 4'b0011;
  localparam logic [FC_W-1:0] FC_CTRL = 4'b0100;
  localparam logic [FC_W-1:0] FC_PC   = 4'b1000;

  function automatic logic is_data(input logic [FC_W-1:0] c);
    return (c == FC_LOW) || (c == FC_HIGH);
  endfunction

  function automatic logic is_stop(input logic [FC_W-1:0] c);
    return (c == FC_CTRL) || (c == FC_PC);
  endfunction
endpackage

// File: rtl/fchp_sampler.sv
module fchp_sampler
  import fchp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_end_i,
  input  logic            cs_ni,
  input  logic [FC_W-1:0] func_i,
  input  logic            rd_wr_i,
  output logic [FC_W-1:0] code_o,
  output logic [FC_W-1:0] new_code_o,
  output logic            new_wr_o,
  output logic            done_o
);
  logic [FC_W-1:0] eff_code, code_q;
  logic            change, done_q;

  assign eff_code   = cs_ni ? FC_NOP : func_i;
  assign change     = cyc_end_i && (eff_code != code_q);
  assign new_code_o = eff_code;
  assign new_wr_o   = change && !rd_wr_i;
  assign code_o     = code_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= FC_NOP;
      done_q <= 1'b0;
    end else begin
      if (cyc_end_i) code_q <= eff_code;
      done_q <= change && is_data(code_q);
    end
  end

  p_cs_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end_i && cs_ni) |=> (code_q == FC_NOP));
  p_hold_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end_i |=> $stable(code_q));
endmodule

// File: rtl/fchp_regfile.sv
module fchp_regfile
  import fchp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CTRL_W   = 8,
  parameter int PC_W     = 8,
  parameter int WORD_BIT = 0,
  parameter int MASK_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FC_W-1:0]   code_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] in_reg_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] in_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PC_W-1:0]   pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      ctrl_q <= '0;
      pc_q   <= '0;
    end else if (wr_i) begin
      case (code_i)
        FC_LOW:  in_q[BYTE_W-1:0] <= data_i[BYTE_W-1:0];
        FC_HIGH: begin
          if (ctrl_q[WORD_BIT]) in_q <= data_i;
          else in_q[DATA_W-1:BYTE_W] <= data_i[BYTE_W-1:0];
        end
        FC_CTRL: ctrl_q <= data_i[CTRL_W-1:0];
        FC_PC: begin
          pc_q             <= data_i[PC_W-1:0];
          ctrl_q[MASK_BIT] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign in_reg_o = in_q;
  assign ctrl_o   = ctrl_q;
  assign pc_o     = pc_q;

  p_pc_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && code_i == FC_PC) |=> ctrl_q[MASK_BIT]);
  p_regs_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(in_q) && $stable(ctrl_q) && $stable(pc_q)));
endmodule

// File: rtl/fcode_host_port.sv
module fcode_host_port
  import fchp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CTRL_W   = 8,
  parameter int PC_W     = 8,
  parameter int WORD_BIT = 0,
  parameter int MASK_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_end_i,
  input  logic              cs_ni,
  input  logic [FC_W-1:0]   func_i,
  input  logic              rd_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] out_reg_i,
  output logic [DATA_W-1:0] in_reg_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              stop_o,
  output logic              xfer_irq_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic [FC_W-1:0] code_q, new_code;
  logic            new_wr, done;

  fchp_sampler u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_end_i  (cyc_end_i),
    .cs_ni      (cs_ni),
    .func_i     (func_i),
    .rd_wr_i    (rd_wr_i),
    .code_o     (code_q),
    .new_code_o (new_code),
    .new_wr_o   (new_wr),
    .done_o     (done)
  );

  fchp_regfile #(
    .DATA_W   (DATA_W),
    .CTRL_W   (CTRL_W),
    .PC_W     (PC_W),
    .WORD_BIT (WORD_BIT),
    .MASK_BIT (MASK_BIT)
  ) u_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (new_wr),
    .code_i   (new_code),
    .data_i   (data_i),
    .in_reg_o (in_reg_o),
    .ctrl_o   (ctrl_o),
    .pc_o     (pc_o)
  );

  // read path follows the live code; only data codes may drive the bus
  always_comb begin
    data_o = '0;
    unique case (func_i)
      FC_LOW:  data_o[BYTE_W-1:0] = out_reg_i[BYTE_W-1:0];
      FC_HIGH: begin
        if (ctrl_o[WORD_BIT]) data_o = out_reg_i;
        else data_o[BYTE_W-1:0] = out_reg_i[DATA_W-1:BYTE_W];
      end
      default: data_o = '0;
    endcase
  end

  assign data_oe_o  = !cs_ni && rd_wr_i && is_data(func_i);
  assign stop_o     = is_stop(code_q);
  assign xfer_irq_o = done;

  p_irq_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_irq_o |=> !xfer_irq_o);
  p_stop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !cyc_end_i) |=> stop_o);
  p_stop_no_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !cyc_end_i) |=> !xfer_irq_o);
endmodule

// File: tb/fcode_host_port_bench.sv
module fcode_host_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        cyc_end_i = 0, cs_ni = 1, rd_wr_i = 0;
  logic [3:0]  func_i = 0;
  logic [15:0] data_i = 0, out_reg_i = 16'hBEEF;
  logic [15:0] data_o, in_reg_o;
  logic        data_oe_o, stop_o, xfer_irq_o;
  logic [7:0]  ctrl_o, pc_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcode_host_port u_fcode_host_port (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_end_i(cyc_end_i), .cs_ni(cs_ni),
    .func_i(func_i), .rd_wr_i(rd_wr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .out_reg_i(out_reg_i), .in_reg_o(in_reg_o),
    .ctrl_o(ctrl_o), .pc_o(pc_o), .stop_o(stop_o), .xfer_irq_o(xfer_irq_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // set inputs at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(logic cs, logic [3:0] f, logic rw, logic [15:0] d, logic cyc);
    cs_ni = cs; func_i = f; rd_wr_i = rw; data_i = d; cyc_end_i = cyc;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 in_reg", in_reg_o, 16'h0);
    chk("R1 ctrl", {8'h0, ctrl_o}, 16'h0);
    chk("R1 pc", {8'h0, pc_o}, 16'h0);
    chk("R1 stop/irq/oe", {13'h0, stop_o, xfer_irq_o, data_oe_o}, 16'h0);
  endtask

  task automatic t_cs_idle;
    step(1, 4'b0010, 0, 16'hAAAA, 1);
    chk("R2 no load", in_reg_o, 16'h0);
    step(1, 4'b0100, 0, 16'h00FF, 1);
    chk("R2 no ctrl", {8'h0, ctrl_o}, 16'h0);
    chk("R2 no stop", {15'h0, stop_o}, 16'h0);
    step(1, 4'b0010, 1, 16'h0, 1);
    chk("R2 bus idle", {15'h0, data_oe_o}, 16'h0);
  endtask

  task automatic t_low;
    step(0, 4'b0010, 0, 16'h12A5, 1);
    chk("R3 low write", in_reg_o, 16'h00A5);
    chk("R3 no drive on write", {15'h0, data_oe_o}, 16'h0);
    step(0, 4'b0010, 1, 16'h0, 1);
    chk("R3 read oe", {15'h0, data_oe_o}, 16'h1);
    chk("R3 read data", data_o, 16'h00EF);
    step(0, 4'b0000, 0, 16'h0, 1);
    chk("R10 irq pulse", {15'h0, xfer_irq_o}, 16'h1);
    step(0, 4'b0000, 0, 16'h0, 1);
    chk("R10 irq single", {15'h0, xfer_irq_o}, 16'h0);
  endtask

  task automatic t_high;
    step(0, 4'b0011, 0, 16'hFF3C, 1);
    chk("R4 upper write", in_reg_o, 16'h3CA5);
    step(0, 4'b0011, 1, 16'h0, 1);
    chk("R4 upper read", data_o, 16'h00BE);
    step(0, 4'b0000, 0, 16'h0, 1);
  endtask

  task automatic t_ctrl;
    step(0, 4'b0100, 0, 16'h0001, 1);
    chk("R6 ctrl load", {8'h0, ctrl_o}, 16'h0001);
    chk("R8 stop rises", {15'h0, stop_o}, 16'h1);
    step(0, 4'b0100, 0, 16'h0002, 1);
    chk("R8 stop held", {15'h0, stop_o}, 16'h1);
    chk("R9 ctrl single load", {8'h0, ctrl_o}, 16'h0001);
    step(0, 4'b0000, 0, 16'h0, 0);
    chk("R8 no release without strobe", {15'h0, stop_o}, 16'h1);
    step(0, 4'b0000, 0, 16'h0, 1);
    chk("R8 release", {15'h0, stop_o}, 16'h0);
    chk("R10 no irq from stop code", {15'h0, xfer_irq_o}, 16'h0);
  endtask

  task automatic t_word;
    step(0, 4'b0011, 0, 16'h1234, 1);
    chk("R5 word write", in_reg_o, 16'h1234);
    step(0, 4'b0011, 1, 16'h0, 1);
    chk("R5 word read", data_o, 16'hBEEF);
    step(0, 4'b0000, 0, 16'h0, 1);
  endtask

  task automatic t_hold;
    step(0, 4'b0010, 0, 16'h0011, 1);
    chk("R9 first write", in_reg_o, 16'h1211);
    for (int i = 0; i < 3; i++) step(0, 4'b0010, 0, 16'h00FF, 1);
    chk("R9 held code no rewrite", in_reg_o, 16'h1211);
    step(0, 4'b0000, 0, 16'h0, 0);
    step(0, 4'b0010, 0, 16'h0077, 1);
    chk("R9 no strobe no change", in_reg_o, 16'h1211);
    step(0, 4'b0000, 0, 16'h0, 1);
  endtask

  task automatic t_pc;
    step(0, 4'b1000, 0, 16'h005A, 1);
    chk("R7 pc load", {8'h0, pc_o}, 16'h005A);
    chk("R7 mask set", {8'h0, ctrl_o}, 16'h0081);
    chk("R8 stop on pc", {15'h0, stop_o}, 16'h1);
    step(0, 4'b0000, 0, 16'h0, 1);
    chk("R8 release pc", {15'h0, stop_o}, 16'h0);
  endtask

  task automatic t_undef;
    step(0, 4'b0101, 0, 16'hFFFF, 1);
    step(0, 4'b1111, 0, 16'hFFFF, 1);
    step(0, 4'b0000, 0, 16'hFFFF, 1);
    chk("R11 in_reg kept", in_reg_o, 16'h1211);
    chk("R11 ctrl/pc kept", {ctrl_o, pc_o}, 16'h815A);
    chk("R11 no stop/irq", {14'h0, stop_o, xfer_irq_o}, 16'h0);
    step(0, 4'b0110, 1, 16'h0, 1);
    chk("R11 no drive", {15'h0, data_oe_o}, 16'h0);
    step(0, 4'b0000, 0, 16'h0, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_cs_idle();
    t_low();
    t_high();
    t_ctrl();
    t_word();
    t_hold();
    t_pc();
    t_undef();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule